// File: doc/BRIEF.md
# Two-Pass Separable Gaussian Smoother

This block smooths a square tile of 32-bit samples with an 11-tap Gaussian kernel, one dimension per run. A run in row mode filters every pixel along its row; a run in column mode filters every pixel along its column. A full 2-D smoothing is two runs: first a row run, then a column run on the row run's output. A corner-detection stage calls the pair three times per tile, once for each squared-gradient image and once for the gradient-product image. The arithmetic is Q16.16 fixed point throughout. Row mode takes plain integers and scales them on entry. Column mode takes Q16.16 words as they are.

The tile lives outside the block. The block reads it through a read port with one cycle of latency and writes results through a write port, in raster order. Before a run, software-side logic loads the eleven kernel weights into a small internal coefficient store. For each output pixel the block steps through the eleven taps one per cycle. It rounds each product to the nearest Q16.16 value, sums the products in a 64-bit accumulator, and writes the sum clipped to 32 bits.

Top module: `gauss_sep_smoother`

## Requirements
- R1: With `mode`=0 (row pass), output(r,c) = sat32( Σ_{t=0..10} rnd( (in(r, c+t−5) sign-extended and shifted left 16) × k_t ) ), where in() is the raw 32-bit input word read as a signed integer.
- R2: With `mode`=1 (column pass), output(r,c) = sat32( Σ_t rnd( in(r+t−5, c) × k_t ) ), where the input word is read as a signed Q16.16 value.
- R3: A tap index below 0 or above DIM−1 uses the nearest edge sample in the filtered direction (replicated border).
- R4: Each product p (Q32.32) is rounded to Q16.16 as (p + 2^15) >> 16 with an arithmetic shift, so a tie rounds toward +infinity; the rounded terms are summed in a 64-bit signed accumulator.
- R5: On writeback the sum clips to 0x7FFFFFFF if it is above that value, and to 0x80000000 if it is below −2^31.
- R6: The coefficient written at `coef_addr`=t (0..10, signed Q16.16) is weight k_t, and it multiplies the sample at offset t−5. A write to an address of 11 or more has no effect.
- R7: Coefficient writes made while a run is active (busy, or its last tap still in flight) are ignored.
- R8: `start` is accepted only while `busy` is low. A `start` pulse during a run neither restarts it nor queues a second run.
- R9: After `start` is accepted on edge E0, the result for pixel p = r·DIM+c is written with `wr_en` high at `wr_addr`=p, visible after edge E0+12+11p. `wr_en` is low in every other cycle. `done` is high for one cycle, together with the final write.
- R10: After synchronous reset, `busy`, `done` and `wr_en` are low.
- R11: The pass direction is latched when `start` is accepted; changes on `mode` during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted while idle) |
| mode | input | 1 | 0 = row pass, 1 = column pass |
| busy | output | 1 | Run in progress (address issue phase) |
| done | output | 1 | One-cycle pulse with the final write |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Coefficient index |
| coef_wdata | input | DW | Coefficient value, signed Q16.16 |
| rd_addr | output | $clog2(DIM·DIM) | Tile read address, row-major |
| rd_data | input | DW | Tile read data, one cycle after rd_addr |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | $clog2(DIM·DIM) | Result address, row-major |
| wr_data | output | DW | Result, signed Q16.16 |

## Verification
The assertions assume that the read port returns data exactly one cycle after the address and that nothing else writes the coefficient store. They also assume that `start` is only meaningful as a pulse, never as a level held across the end of a run. The stimulus uses a bench memory with a one-cycle registered read. It raises `start` for a single cycle, except for one deliberate pulse in the middle of a run. Input magnitudes are chosen so that the 64-bit accumulator never wraps. Overflow therefore appears only as 32-bit clipping, which the clipping pattern produces on purpose.

// File: rtl/gs_pkg.sv
// Shared definitions for the separable smoother.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package gs_pkg;
    // Direction of one filtering run.
    typedef enum logic {
        PASS_ROW = 1'b0,
        PASS_COL = 1'b1
    } pass_e;
endpackage

// File: rtl/gs_coef_bank.sv
// Coefficient store: TAPS signed fixed-point weights, written one at a time
// while no run is active, read combinationally by tap index.
// Assumes: rd_tap is always below TAPS.
module gs_coef_bank #(
    parameter int TAPS = 11,
    parameter int DW   = 32,
    parameter int TW   = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic [TW-1:0] rd_tap,
    output logic [DW-1:0] rd_val
);
    logic [TAPS-1:0][DW-1:0] weight_q;

    // Capture a weight when the write is legal and in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weight_q <= '0;
        end else if (wr_en && !active && (int'(wr_idx) < TAPS)) begin
            weight_q[wr_idx] <= wr_val;
        end
    end

    // Present the weight for the tap currently in the multiply stage.
    always_comb rd_val = weight_q[rd_tap];

    // R7: weights cannot move while a run is using them
    a_r7_coef_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(weight_q));
endmodule

// File: rtl/gs_seq.sv
// Run sequencer: walks pixels in raster order and, per pixel, taps 0..TAPS-1,
// issuing one read address per cycle with edge-replicated clamping.
// Assumes: TAPS is odd and below DIM; the read port has one cycle of latency.
module gs_seq
    import gs_pkg::*;
#(
    parameter int DIM  = 96,
    parameter int TAPS = 11,
    parameter int AW   = $clog2(DIM*DIM),
    parameter int CW   = $clog2(DIM),
    parameter int TW   = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    output logic          busy,
    output logic          iss_valid,
    output logic [AW-1:0] iss_addr,
    output logic [TW-1:0] iss_tap,
    output logic          iss_first,
    output logic          iss_last,
    output logic          iss_final,
    output logic [AW-1:0] iss_pix,
    output pass_e         iss_mode
);
    localparam int RADIUS = TAPS / 2;

    logic          busy_q;
    pass_e         mode_q;
    logic [CW-1:0] row_q, col_q, pos_cl;
    logic [TW-1:0] tap_q;
    logic          tap_end, col_end, row_end;

    always_comb begin
        tap_end = (tap_q == TW'(TAPS-1));
        col_end = (col_q == CW'(DIM-1));
        row_end = (row_q == CW'(DIM-1));
    end

    // Accept a run while idle, then step tap, column and row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mode_q <= PASS_ROW;
            row_q  <= '0;
            col_q  <= '0;
            tap_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                mode_q <= pass_e'(mode);
                row_q  <= '0;
                col_q  <= '0;
                tap_q  <= '0;
            end
        end else if (!tap_end) begin
            tap_q <= tap_q + 1'b1;
        end else begin
            tap_q <= '0;
            if (!col_end) begin
                col_q <= col_q + 1'b1;
            end else begin
                col_q <= '0;
                if (row_end) begin
                    row_q  <= '0;
                    busy_q <= 1'b0;
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end
        end
    end

    // Clamp the tap position to the tile edge in the filtered direction.
    always_comb begin
        int pos;
        pos = ((mode_q == PASS_ROW) ? int'(col_q) : int'(row_q)) + int'(tap_q) - RADIUS;
        if (pos < 0) pos = 0;
        else if (pos > DIM - 1) pos = DIM - 1;
        pos_cl = CW'(pos);
    end

    // Form the read address and the tags that travel with the read.
    always_comb begin
        if (mode_q == PASS_ROW) iss_addr = AW'(row_q) * AW'(DIM) + AW'(pos_cl);
        else                    iss_addr = AW'(pos_cl) * AW'(DIM) + AW'(col_q);
        iss_pix   = AW'(row_q) * AW'(DIM) + AW'(col_q);
        iss_valid = busy_q;
        iss_tap   = tap_q;
        iss_first = (tap_q == '0);
        iss_last  = tap_end;
        iss_final = busy_q && tap_end && col_end && row_end;
        iss_mode  = mode_q;
        busy      = busy_q;
    end

    // R11: direction is fixed for the whole run
    a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(mode_q));
    // R3: clamped addresses never leave the tile
    a_r3_addr_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(iss_addr) < DIM*DIM));
    // R8: a run ends only after its final tap, whatever start does
    a_r8_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !iss_final) |=> busy_q);
endmodule

// File: rtl/gs_mac.sv
// Multiply-accumulate and writeback: aligns returning samples with their tags,
// scales integers into Q format in row mode, rounds each product, accumulates
// in ACCW bits and clips to DW bits when the last tap of a pixel arrives.
// Assumes: rd_data belongs to the address issued one cycle earlier.
module gs_mac
    import gs_pkg::*;
#(
    parameter int DW   = 32,
    parameter int ACCW = 64,
    parameter int FRAC = 16,
    parameter int AW   = 14,
    parameter int TW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [TW-1:0] iss_tap,
    input  logic          iss_first,
    input  logic          iss_last,
    input  logic          iss_final,
    input  logic [AW-1:0] iss_pix,
    input  pass_e         iss_mode,
    input  logic [DW-1:0] rd_data,
    output logic [TW-1:0] coef_tap,
    input  logic [DW-1:0] coef_val,
    output logic          pipe_busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done
);
    localparam int PW = ACCW + DW;
    localparam logic signed [PW-1:0]   HALF   = PW'(1) << (FRAC - 1);
    localparam logic signed [ACCW-1:0] SAT_HI = (ACCW'(1) << (DW - 1)) - ACCW'(1);
    localparam logic signed [ACCW-1:0] SAT_LO = ~SAT_HI;

    logic          v1_q, first1_q, last1_q, final1_q;
    logic [TW-1:0] tap1_q;
    logic [AW-1:0] pix1_q;
    pass_e         mode1_q;

    logic signed [ACCW-1:0] acc_q, samp, term, acc_next;
    logic signed [PW-1:0]   samp_x, coef_x, prod, rounded;
    logic        [DW-1:0]   clipped;

    // Delay the issue tags by the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q     <= 1'b0;
            first1_q <= 1'b0;
            last1_q  <= 1'b0;
            final1_q <= 1'b0;
            tap1_q   <= '0;
            pix1_q   <= '0;
            mode1_q  <= PASS_ROW;
        end else begin
            v1_q     <= iss_valid;
            first1_q <= iss_first;
            last1_q  <= iss_last;
            final1_q <= iss_final;
            tap1_q   <= iss_tap;
            pix1_q   <= iss_pix;
            mode1_q  <= iss_mode;
        end
    end

    // Scale, multiply, round and accumulate one tap.
    always_comb begin
        samp = {{(ACCW-DW){rd_data[DW-1]}}, rd_data};
        if (mode1_q == PASS_ROW) samp = samp <<< FRAC;
        samp_x   = {{DW{samp[ACCW-1]}}, samp};
        coef_x   = {{ACCW{coef_val[DW-1]}}, coef_val};
        prod     = samp_x * coef_x;
        rounded  = (prod + HALF) >>> FRAC;
        term     = ACCW'(rounded);
        acc_next = first1_q ? term : (acc_q + term);
    end

    // Clip the finished sum into the output word.
    always_comb begin
        if (acc_next > SAT_HI)      clipped = DW'(SAT_HI);
        else if (acc_next < SAT_LO) clipped = DW'(SAT_LO);
        else                        clipped = DW'(acc_next);
    end

    // Hold the running sum and emit the write on the last tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            done    <= 1'b0;
        end else begin
            if (v1_q) acc_q <= acc_next;
            wr_en <= v1_q && last1_q;
            done  <= v1_q && final1_q;
            if (v1_q && last1_q) begin
                wr_addr <= pix1_q;
                wr_data <= clipped;
            end
        end
    end

    always_comb begin
        coef_tap  = tap1_q;
        pipe_busy = v1_q;
    end

    // R9: writes are spaced by at least one idle cycle
    a_r9_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R9: completion coincides with a write
    a_r9_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wr_en);
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/gauss_sep_smoother.sv
// Top level: one-dimensional 11-tap Gaussian pass over a DIM x DIM tile held
// in external memory, row or column direction chosen per run.
// Assumes: external read port has one cycle latency; weights loaded while idle.
module gauss_sep_smoother
    import gs_pkg::*;
#(
    parameter int DIM  = 96,
    parameter int TAPS = 11,
    parameter int DW   = 32,
    parameter int ACCW = 64,
    parameter int FRAC = 16,
    localparam int AW  = $clog2(DIM*DIM),
    localparam int TW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    output logic          busy,
    output logic          done,
    input  logic          coef_we,
    input  logic [TW-1:0] coef_addr,
    input  logic [DW-1:0] coef_wdata,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic          iss_valid, iss_first, iss_last, iss_final, pipe_busy;
    logic [TW-1:0] iss_tap, coef_tap;
    logic [AW-1:0] iss_pix;
    logic [DW-1:0] coef_val;
    pass_e         iss_mode;

    gs_seq #(.DIM(DIM), .TAPS(TAPS), .AW(AW), .TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
        .iss_valid(iss_valid), .iss_addr(rd_addr), .iss_tap(iss_tap),
        .iss_first(iss_first), .iss_last(iss_last), .iss_final(iss_final),
        .iss_pix(iss_pix), .iss_mode(iss_mode)
    );

    gs_coef_bank #(.TAPS(TAPS), .DW(DW), .TW(TW)) u_coef (
        .clk(clk), .rst_n(rst_n), .active(busy || pipe_busy),
        .wr_en(coef_we), .wr_idx(coef_addr), .wr_val(coef_wdata),
        .rd_tap(coef_tap), .rd_val(coef_val)
    );

    gs_mac #(.DW(DW), .ACCW(ACCW), .FRAC(FRAC), .AW(AW), .TW(TW)) u_mac (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tap(iss_tap),
        .iss_first(iss_first), .iss_last(iss_last), .iss_final(iss_final),
        .iss_pix(iss_pix), .iss_mode(iss_mode), .rd_data(rd_data),
        .coef_tap(coef_tap), .coef_val(coef_val), .pipe_busy(pipe_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );
endmodule

// File: tb/gauss_sep_smoother_test.sv
`timescale 1ns/1ps
module gauss_sep_smoother_test;
    localparam int DIM = 8;
    localparam int N = DIM*DIM;
    localparam int TAPS = 11;
    localparam int AW = $clog2(N);
    localparam int TW = $clog2(TAPS);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, mode, busy, done, coef_we, wr_en;
    logic [TW-1:0] coef_addr;
    logic [31:0] coef_wdata, rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;

    gauss_sep_smoother #(.DIM(DIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
        .done(done), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    logic [31:0] src [N];
    logic [31:0] dst [N];
    logic [31:0] expv [N];
    longint km [TAPS];
    int checks = 0;
    int fails = 0;

    // bench memory: registered read, write port
    always @(posedge clk) begin
        rd_data <= src[rd_addr];
        if (wr_en) dst[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference: sum of rounded products, replicated border, clip to 32 bits
    function automatic void model(input bit m);
        for (int r = 0; r < DIM; r++) begin
            for (int c = 0; c < DIM; c++) begin
                longint acc = 0;
                for (int t = 0; t < TAPS; t++) begin
                    int pos = (m ? r : c) + t - TAPS/2;
                    int idx;
                    longint sv, p;
                    if (pos < 0) pos = 0;
                    if (pos > DIM-1) pos = DIM-1;
                    idx = m ? pos*DIM + c : r*DIM + pos;
                    sv = longint'($signed(src[idx]));
                    if (!m) sv = sv * 65536;
                    p = sv * km[t];
                    acc += (p + 32768) >>> 16;
                end
                if (acc > 64'sh7FFFFFFF) acc = 64'sh7FFFFFFF;
                if (acc < -64'sh80000000) acc = -64'sh80000000;
                expv[r*DIM+c] = 32'(acc);
            end
        end
    endfunction

    task automatic push_coefs();
        for (int t = 0; t < TAPS; t++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_addr = TW'(t); coef_wdata = 32'(km[t]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic run_pass(input bit m, input bit disturb, input string req);
        int lastn = 11*N + 1;
        model(m);
        @(negedge clk); start = 1'b1; mode = m;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n <= lastn + 3; n++) begin
            bit ew = (n >= 12) && (((n-12) % 11) == 0) && (((n-12)/11) < N);
            chk(wr_en === ew, "R9 write strobe", longint'(wr_en), longint'(ew));
            if (ew) begin
                int p = (n-12)/11;
                chk(int'(wr_addr) == p, "R9 write order", longint'(wr_addr), p);
                chk(wr_data === expv[p], req, longint'($signed(wr_data)), longint'($signed(expv[p])));
            end
            chk(done === (n == lastn), "R9 done", longint'(done), longint'(n == lastn));
            if (n == 0) chk(busy === 1'b1, "R8 busy", longint'(busy), 1);
            if (n == lastn + 3) chk(busy === 1'b0, "R8 single run", longint'(busy), 0);
            if (disturb && n == 5) begin
                start = 1'b1; mode = ~m; coef_we = 1'b1;
                coef_addr = TW'(5); coef_wdata = 32'h00FF_0000;
            end
            if (disturb && n == 6) begin
                start = 1'b0; mode = m; coef_we = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic gauss_coefs();
        longint b [TAPS] = '{1, 10, 45, 120, 210, 252, 210, 120, 45, 10, 1};
        for (int t = 0; t < TAPS; t++) km[t] = b[t] * 64;
    endtask

    task automatic copy_back();
        for (int i = 0; i < N; i++) src[i] = dst[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; coef_we = 1'b0;
        coef_addr = '0; coef_wdata = '0;
        for (int i = 0; i < N; i++) src[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0, "R10 busy", longint'(busy), 0);
        chk(done === 1'b0, "R10 done", longint'(done), 0);
        chk(wr_en === 1'b0, "R10 wr_en", longint'(wr_en), 0);
        rst_n = 1'b1;

        // R1: row pass on random integers with Gaussian weights
        gauss_coefs();
        push_coefs();
        for (int i = 0; i < N; i++) src[i] = 32'(int'($urandom_range(10000)) - 5000);
        run_pass(1'b0, 1'b0, "R1 row pass");

        // R2: column pass on the row result
        copy_back();
        run_pass(1'b1, 1'b0, "R2 column pass");

        // R3 / R6: asymmetric weights, impulses at the tile edges
        for (int t = 0; t < TAPS; t++) km[t] = longint'(t + 1) * 65536;
        // R6: out-of-range coefficient address must be ignored
        @(negedge clk); coef_we = 1'b1; coef_addr = TW'(12); coef_wdata = 32'h7FFF_0000;
        push_coefs();
        for (int i = 0; i < N; i++) src[i] = '0;
        src[0] = 32'd7; src[DIM-1] = 32'd3; src[N-1] = 32'hFFFF_FFFB; src[DIM*3] = 32'd2;
        run_pass(1'b0, 1'b0, "R3 R6 row border");
        run_pass(1'b1, 1'b0, "R3 R6 column border");

        // R4: ties round toward +infinity
        for (int t = 0; t < TAPS; t++) km[t] = 0;
        km[5] = 32768; km[0] = 32768;
        push_coefs();
        for (int i = 0; i < N; i++) src[i] = 32'((i % 7) - 3);
        run_pass(1'b1, 1'b0, "R4 rounding");

        // R5: saturation both ways
        for (int t = 0; t < TAPS; t++) km[t] = 65536;
        push_coefs();
        for (int i = 0; i < N; i++)
            src[i] = (i < N/2) ? 32'h7FFF_0000 : ((i % 3 == 0) ? 32'h0 : 32'h8000_0000);
        run_pass(1'b1, 1'b0, "R5 saturation");

        // R7 R8 R11: disturbances during a run change nothing
        gauss_coefs();
        push_coefs();
        for (int i = 0; i < N; i++) src[i] = 32'(int'($urandom_range(2000)) - 1000);
        run_pass(1'b0, 1'b1, "R7 R8 R11 disturbed run");
        run_pass(1'b0, 1'b0, "R7 weights kept");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule